// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets each of a small group of cores interrupt any other core. Every core owns a command port. A command has an opcode and a 16-bit parameter, and the parameter names a core index. The block stores a pending matrix with one bit for each sender and receiver pair. Each receiver has one interrupt line, and that line stays high while any sender still holds a pending bit toward it.

Software uses the block in four steps:

1. A sender issues a status query to learn whether its previous interrupt to a target has been taken.
2. The sender then raises the interrupt.
3. The receiver asks which senders are waiting.
4. The receiver acknowledges each of those senders in turn.

Interrupts from several senders to one receiver merge onto that receiver's single line. The source query then returns several bits, and each sender is acknowledged on its own.

When several cores present a command in the same cycle, a fixed-priority arbiter serves the lowest-numbered core. The other requesting cores see their stall flag set and must present the command again. The readback value of a served command appears in a register one cycle after it is accepted.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset, every pending bit is clear, `irq_o` is 0 and `rvalid_o` is 0.
- R2: A raise command (opcode 5'h02) from core S with parameter T, where T differs from S and T < N_CORES, sets the pending bit from S to T. `irq_o[T]` is high from the next cycle.
- R3: A status command (opcode 5'h01) from core S with parameter T returns readback 1 if S has a pending bit toward T, and 0 otherwise.
- R4: A source command (opcode 5'h03) from core R returns a bitmask in which bit S is set exactly when S has a pending bit toward R. Several senders to one receiver give several set bits.
- R5: An acknowledge command (opcode 5'h04) from core R with parameter S clears only the bit from S to R. All other pending bits stay unchanged.
- R6: `irq_o[R]` stays high until every sender bit toward R has been acknowledged, and falls only in the cycle after the last such acknowledge.
- R7: A raise command whose parameter equals the issuing core's index sets no pending bit.
- R8: When several cores assert `cmd_valid_i` in one cycle, only the lowest-indexed one is executed. Every other requesting core sees `stall_o` high in that cycle, and its command has no effect. A lone requester is never stalled.
- R9: One cycle after a command is accepted, `rvalid_o` is 1, `rcore_o` holds the issuing core's index and `rdata_o` holds its readback. Raise, acknowledge and unknown opcodes give readback 0. In a cycle with no accepted command, `rvalid_o` is 0 the next cycle.
- R10: A raise or acknowledge whose parameter is N_CORES or larger changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | N_CORES | One command strobe per core |
| cmd_op_i | input | N_CORES*5 | Opcode per core, core i in bits [5i+4:5i] |
| cmd_param_i | input | N_CORES*16 | Parameter per core, core i in bits [16i+15:16i] |
| stall_o | output | N_CORES | Core's command was not served this cycle |
| irq_o | output | N_CORES | Interrupt line per receiving core |
| rvalid_o | output | 1 | Readback register holds a fresh result |
| rcore_o | output | 2 | Core that issued the command now in the readback register |
| rdata_o | output | 16 | Readback value |

## Verification
A single raise followed by status queries from the sender and from an unrelated core shows that status depends on the pair and not only on the target. Three raises toward one receiver, followed by acknowledges one at a time, show that the source mask merges the senders and that each acknowledge clears only its own bit. The same sequence shows that the interrupt line falls only after the last acknowledge. Self-targeted and out-of-range raises are checked through both the interrupt lines and a source query. Two cores requesting in the same cycle show which core is served, which core is stalled, and that the stalled command leaves no trace in the matrix.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_STATUS = 5'h01,
    OP_RAISE  = 5'h02,
    OP_SOURCE = 5'h03,
    OP_ACK    = 5'h04
  } ipi_op_e;
endpackage

// File: rtl/ipi_arb.sv
module ipi_arb #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // walk from the top so the lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) a_grant_onehot_r8: assert ($onehot(gnt_o) && ((gnt_o & req_i) == gnt_o));
  end
endmodule

// File: rtl/ipi_matrix.sv
module ipi_matrix
  import ipi_pkg::*;
#(
  parameter int unsigned N       = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exec_i,
  input  logic [IDX_W-1:0]   issuer_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [PARAM_W-1:0] param_i,
  output logic [N-1:0]       irq_o,
  output logic               rvalid_o,
  output logic [IDX_W-1:0]   rcore_o,
  output logic [DATA_W-1:0]  rdata_o
);
  // pend_q[s][r]: sender s has an unacknowledged interrupt at receiver r
  logic [N-1:0][N-1:0] pend_q, pend_d;
  logic [N-1:0][N-1:0] col;   // col[r][s] = pend_q[s][r]
  logic                tgt_ok;
  logic [IDX_W-1:0]    tgt;
  logic [DATA_W-1:0]   rd_d;

  assign tgt_ok = (param_i < PARAM_W'(N));
  assign tgt    = param_i[IDX_W-1:0];

  for (genvar r = 0; r < N; r++) begin : g_rx
    for (genvar s = 0; s < N; s++) begin : g_tx
      assign col[r][s] = pend_q[s][r];
    end
    assign irq_o[r] = |col[r];

    p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o[r]) |-> $past(exec_i && op_i == OP_ACK && issuer_i == IDX_W'(r)));
    p_no_self_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q[r][r]);
  end

  always_comb begin
    pend_d = pend_q;
    if (exec_i && tgt_ok) begin
      if (op_i == OP_RAISE && tgt != issuer_i) pend_d[issuer_i][tgt] = 1'b1;
      if (op_i == OP_ACK)                      pend_d[tgt][issuer_i] = 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    case (op_i)
      OP_STATUS: rd_d[0]   = tgt_ok && pend_q[issuer_i][tgt];
      OP_SOURCE: rd_d[N-1:0] = col[issuer_i];
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      rvalid_o <= 1'b0;
      rcore_o  <= '0;
      rdata_o  <= '0;
    end else begin
      pend_q   <= pend_d;
      rvalid_o <= exec_i;
      if (exec_i) begin
        rcore_o <= issuer_i;
        rdata_o <= rd_d;
      end
    end
  end

  p_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_RAISE && tgt_ok && tgt != issuer_i) |=> irq_o[$past(tgt)]);
  p_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (rvalid_o && rcore_o == $past(issuer_i)));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> !rvalid_o);
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CORES-1:0]         cmd_valid_i,
  input  logic [N_CORES*OP_W-1:0]    cmd_op_i,
  input  logic [N_CORES*PARAM_W-1:0] cmd_param_i,
  output logic [N_CORES-1:0]         stall_o,
  output logic [N_CORES-1:0]         irq_o,
  output logic                       rvalid_o,
  output logic [IDX_W-1:0]           rcore_o,
  output logic [DATA_W-1:0]          rdata_o
);
  logic [N_CORES-1:0] gnt;
  logic [IDX_W-1:0]   sel;
  logic               any;
  logic [OP_W-1:0]    op_sel;
  logic [PARAM_W-1:0] param_sel;

  ipi_arb #(.N(N_CORES), .IDX_W(IDX_W)) i_arb (
    .req_i (cmd_valid_i),
    .gnt_o (gnt),
    .idx_o (sel),
    .any_o (any)
  );

  assign op_sel    = cmd_op_i[sel*OP_W +: OP_W];
  assign param_sel = cmd_param_i[sel*PARAM_W +: PARAM_W];
  assign stall_o   = cmd_valid_i & ~gnt;

  ipi_matrix #(
    .N(N_CORES), .IDX_W(IDX_W), .PARAM_W(PARAM_W), .DATA_W(DATA_W)
  ) i_matrix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .exec_i   (any),
    .issuer_i (sel),
    .op_i     (op_sel),
    .param_i  (param_sel),
    .irq_o    (irq_o),
    .rvalid_o (rvalid_o),
    .rcore_o  (rcore_o),
    .rdata_o  (rdata_o)
  );

  p_lead_not_stalled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i[0] |-> !stall_o[0]);
  p_single_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_valid_i) |-> ($countones(stall_o) == $countones(cmd_valid_i) - 1));
endmodule

// File: tb/test_ipi_ctrl.sv
module test_ipi_ctrl;
  localparam int N = 4;
  localparam logic [4:0] ST = 5'h01, RA = 5'h02, SR = 5'h03, AK = 5'h04;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  valid = '0;
  logic [N*5-1:0]  op = '0;
  logic [N*16-1:0] prm = '0;
  logic [N-1:0]  stall, irq;
  logic          rvalid;
  logic [1:0]    rcore;
  logic [15:0]   rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ipi_ctrl i_ipi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op),
    .cmd_param_i(prm), .stall_o(stall), .irq_o(irq), .rvalid_o(rvalid),
    .rcore_o(rcore), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input int c, input logic [4:0] o, input logic [15:0] p,
                     output logic [15:0] rd);
    @(negedge clk);
    valid = '0; valid[c] = 1'b1;
    op[c*5 +: 5] = o; prm[c*16 +: 16] = p;
    @(negedge clk);
    valid = '0;
    rd = rdata;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    chk("R1 rvalid", rvalid, 0);
    chk("R1 stall", stall, 0);
  endtask

  task automatic t_raise_status;
    logic [15:0] rd;
    cmd(0, RA, 2, rd);
    chk("R2 irq after raise", irq, 4'b0100);
    chk("R9 raise readback", rd, 0);
    cmd(0, ST, 2, rd);
    chk("R3 status pending", rd, 1);
    cmd(1, ST, 2, rd);
    chk("R3 status other sender", rd, 0);
    cmd(0, ST, 3, rd);
    chk("R3 status other target", rd, 0);
  endtask

  task automatic t_merge_ack;
    logic [15:0] rd;
    cmd(1, RA, 2, rd);
    cmd(3, RA, 2, rd);
    cmd(2, SR, 0, rd);
    chk("R4 merged sources", rd, 16'b1011);
    chk("R9 rcore", rcore, 2);
    chk("R9 rvalid", rvalid, 1);
    @(negedge clk);
    chk("R9 idle rvalid", rvalid, 0);
    cmd(2, AK, 1, rd);
    chk("R9 ack readback", rd, 0);
    cmd(2, SR, 0, rd);
    chk("R5 only sender 1 cleared", rd, 16'b1001);
    chk("R6 irq held", irq, 4'b0100);
    cmd(2, AK, 0, rd);
    chk("R6 irq held one left", irq, 4'b0100);
    cmd(2, AK, 3, rd);
    chk("R6 irq falls after last ack", irq, 0);
  endtask

  task automatic t_self_range;
    logic [15:0] rd;
    cmd(1, RA, 1, rd);
    chk("R7 self raise irq", irq, 0);
    cmd(1, SR, 0, rd);
    chk("R7 self raise sources", rd, 0);
    cmd(0, RA, 7, rd);
    chk("R10 out of range raise", irq, 0);
    cmd(3, RA, 0, rd);
    cmd(0, AK, 16'h0013, rd);
    chk("R10 out of range ack", irq, 4'b0001);
    cmd(0, AK, 3, rd);
    chk("R5 cleanup", irq, 0);
  endtask

  task automatic t_arb;
    logic [15:0] rd;
    @(negedge clk);
    valid = 4'b1010;
    op[1*5 +: 5] = RA; prm[1*16 +: 16] = 0;
    op[3*5 +: 5] = RA; prm[3*16 +: 16] = 0;
    #1;
    chk("R8 stall pattern", stall, 4'b1000);
    @(negedge clk);
    valid = '0;
    chk("R8 winner executed", irq, 4'b0001);
    chk("R9 winner rcore", rcore, 1);
    cmd(0, SR, 0, rd);
    chk("R8 stalled command dropped", rd, 16'b0010);
    cmd(2, RA, 1, rd);
    #1;
    chk("R8 lone requester", stall, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raise_status();
    t_merge_ack();
    t_self_range();
    t_arb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule